// File: doc/BRIEF.md
# Audio Serial Clock Generator (Master/Slave)

This block supplies the frame clock and the bit clock of an audio serial link. It works in one of two roles. In slave role, frame and bit clocks arriving from another device are passed combinationally to the outputs. In master role, the block runs from a master clock at 256 times the sample rate and derives both output clocks from an internal frame counter. The bit clock runs at 64 or 48 times the sample rate. The 48fs ratio uses a fractional accumulator, so its bit periods alternate between 5 and 6 master clocks and three bit periods always span 16 master clocks.

Two active-low resets, `init_rst_n` and `sys_rst_n`, act together. While either is low, both outputs are held low, the divider is cleared, and the role, clock-mode field and ratio request are captured on every master-clock edge. When both resets are high, those settings are frozen until the next reset. The clock-mode value 2 accepts only the 64fs ratio. A 48fs request in that mode raises `ratio_err` and the block runs at 64fs.

A three-state controller sequences the block. The states are SILENT, SLAVE and MASTER. An asynchronous reset sends any state to SILENT. On the first clock edge with both resets high, the transition *start_slave* (SILENT to SLAVE) or *start_master* (SILENT to MASTER) is taken, according to the captured role. SLAVE and MASTER each hold until the next reset.

Top module: `audio_clk_gen`

## Requirements
- R1: While `init_rst_n` is low, both `lrclk_out` and `bclk_out` are 0 in either role.
- R2: While `init_rst_n` is high and `sys_rst_n` is low, both outputs are 0 in either role.
- R3: After both resets go high, the outputs stay 0 until the first rising `clk` edge. On that edge the controller moves to SLAVE when the captured `master_mode` is 0, or to MASTER when it is 1.
- R4: In SLAVE, `lrclk_out` equals `lrclk_in` and `bclk_out` equals `bclk_in`, with no clock delay.
- R5: In MASTER, take k as the number of rising `clk` edges since release and c = (k-1) mod 256. Define h = floor(c·2·B/256), where B is the effective bits per frame. Then `bclk_out` = h mod 2 and `lrclk_out` = 1 exactly when h ≥ B. The frame clock is therefore low for the first 128 clocks of each frame and high for the last 128.
- R6: With B = 64, the bit clock has a period of 4 master clocks, low for 2 and high for 2.
- R7: With B = 48, there are 48 bit periods per 256-clock frame, and the bit-clock edges follow the R5 formula.
- R8: The effective B is 48 only when `ratio48` = 1 and `clk_mode` ≠ 2. When `ratio48` = 1 and `clk_mode` = 2, `ratio_err` is 1 and B = 64. Otherwise `ratio_err` is 0.
- R9: In MASTER, `lrclk_out` changes only on a clock edge where `bclk_out` falls. In each half-frame before the frame clock rises, there are B/2 rising bit-clock edges.
- R10: Changes to `master_mode`, `clk_mode` or `ratio48` while both resets are high have no effect on the outputs or on `ratio_err` until the next reset.
- R11: A reset asserted in the middle of a frame restarts the counter. After release, output follows R5 again from c = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256fs |
| init_rst_n | input | 1 | Initial reset, active low, asynchronous assert |
| sys_rst_n | input | 1 | System reset, active low, asynchronous assert |
| master_mode | input | 1 | Role request: 1 = master, 0 = slave |
| clk_mode | input | 2 | Clock-mode field; value 2 permits only 64fs |
| ratio48 | input | 1 | Ratio request: 1 = 48fs, 0 = 64fs |
| lrclk_in | input | 1 | External frame clock (slave) |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_out | output | 1 | Frame clock output |
| bclk_out | output | 1 | Bit clock output |
| ratio_err | output | 1 | 48fs requested in the 64fs-only mode |

## Verification
The failures that matter here are internal states that drift: a corrupt accumulator or half-period count, a frame position off by one, or a mode capture taken at the wrong time. A fault in the half-period accumulator moves a bit-clock edge away from its arithmetic position within 8 master clocks in the 48fs pattern, and within 2 in the 64fs pattern. A wrong frame position moves the frame-clock edge within one 256-clock frame. A mode captured at the wrong time shows up at the first clock after reset release, either as the wrong role or as a wrong `ratio_err`. The bench compares both outputs on every cycle against the R5 arithmetic for each legal and illegal mode combination. It also checks passthrough in slave role and restarts after a mid-frame reset.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    typedef enum logic [1:0] {
        ST_SILENT = 2'd0,
        ST_SLAVE  = 2'd1,
        ST_MASTER = 2'd2
    } clk_state_e;

    localparam logic [1:0] CKM_STRICT64 = 2'd2;

endpackage

// File: rtl/audio_clk_mode_latch.sv
module audio_clk_mode_latch
    import audio_clk_pkg::*;
(
    input  logic       clk,
    input  logic       hold,
    input  logic       master_req,
    input  logic [1:0] ckm_req,
    input  logic       r48_req,
    output logic       is_master,
    output logic       use48,
    output logic       illegal48
);

    logic strict_q;
    logic r48_q;

    always_ff @(posedge clk) begin
        if (hold) begin
            is_master <= master_req;
            strict_q  <= (ckm_req == CKM_STRICT64);
            r48_q     <= r48_req;
        end
    end

    always_comb begin
        use48     = r48_q && !strict_q;
        illegal48 = r48_q && strict_q;
    end

endmodule

// File: rtl/audio_clk_divider.sv
module audio_clk_divider #(
    parameter int MCLK_PER_FS = 256,
    parameter int BITS_HI     = 64,
    parameter int BITS_LO     = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use48,
    output logic bclk,
    output logic lrclk
);

    localparam int CW = $clog2(MCLK_PER_FS);
    localparam int AW = CW + 1;
    localparam int HW = $clog2(2 * BITS_HI) + 1;
    localparam logic [AW-1:0] STEP_HI = AW'(2 * BITS_HI);
    localparam logic [AW-1:0] STEP_LO = AW'(2 * BITS_LO);
    localparam logic [AW-1:0] WRAP    = AW'(MCLK_PER_FS);
    localparam logic [CW-1:0] LAST    = CW'(MCLK_PER_FS - 1);

    logic [CW-1:0] pos_q;
    logic [AW-1:0] acc_q, acc_sum, acc_n, step;
    logic [HW-1:0] half_q, half_n, bits_eff;
    logic          frame_end;

    always_comb begin
        step      = use48 ? STEP_LO : STEP_HI;
        bits_eff  = use48 ? HW'(BITS_LO) : HW'(BITS_HI);
        acc_sum   = acc_q + step;
        frame_end = (pos_q == LAST);
        if (frame_end) begin
            acc_n  = '0;
            half_n = '0;
        end else if (acc_sum >= WRAP) begin
            acc_n  = acc_sum - WRAP;
            half_n = half_q + 1'b1;
        end else begin
            acc_n  = acc_sum;
            half_n = half_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            acc_q  <= '0;
            half_q <= '0;
            bclk   <= 1'b0;
            lrclk  <= 1'b0;
        end else if (run) begin
            pos_q  <= frame_end ? '0 : pos_q + 1'b1;
            acc_q  <= acc_n;
            half_q <= half_n;
            bclk   <= half_n[0];
            lrclk  <= (half_n >= bits_eff);
        end
    end

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
    import audio_clk_pkg::*;
#(
    parameter int MCLK_PER_FS = 256,
    parameter int BITS_HI     = 64,
    parameter int BITS_LO     = 48
) (
    input  logic       clk,
    input  logic       init_rst_n,
    input  logic       sys_rst_n,
    input  logic       master_mode,
    input  logic [1:0] clk_mode,
    input  logic       ratio48,
    input  logic       lrclk_in,
    input  logic       bclk_in,
    output logic       lrclk_out,
    output logic       bclk_out,
    output logic       ratio_err
);

    logic       rst_n;
    logic       is_master, use48_q;
    logic       gen_bclk, gen_lrclk;
    clk_state_e state_q, state_n;

    assign rst_n = init_rst_n & sys_rst_n;

    audio_clk_mode_latch u_latch (
        .clk        (clk),
        .hold       (!rst_n),
        .master_req (master_mode),
        .ckm_req    (clk_mode),
        .r48_req    (ratio48),
        .is_master  (is_master),
        .use48      (use48_q),
        .illegal48  (ratio_err)
    );

    audio_clk_divider #(
        .MCLK_PER_FS (MCLK_PER_FS),
        .BITS_HI     (BITS_HI),
        .BITS_LO     (BITS_LO)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_MASTER),
        .use48 (use48_q),
        .bclk  (gen_bclk),
        .lrclk (gen_lrclk)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SILENT;
        else        state_q <= state_n;
    end

    // transitions: start_slave / start_master leave SILENT
    always_comb begin
        unique case (state_q)
            ST_SILENT: state_n = is_master ? ST_MASTER : ST_SLAVE;
            ST_SLAVE:  state_n = ST_SLAVE;
            ST_MASTER: state_n = ST_MASTER;
            default:   state_n = ST_SILENT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SLAVE: begin
                lrclk_out = lrclk_in;
                bclk_out  = bclk_in;
            end
            ST_MASTER: begin
                lrclk_out = gen_lrclk;
                bclk_out  = gen_bclk;
            end
            default: begin
                lrclk_out = 1'b0;
                bclk_out  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/audio_clk_gen_chk.sv
module audio_clk_gen_chk
    import audio_clk_pkg::*;
#(
    parameter int BITS_HI = 64,
    parameter int BITS_LO = 48
) (
    input logic       clk,
    input logic       init_rst_n,
    input logic       sys_rst_n,
    input logic       lrclk_in,
    input logic       bclk_in,
    input logic       lrclk_out,
    input logic       bclk_out,
    input logic       ratio_err,
    input logic       use48,
    input clk_state_e st
);

    localparam int CNTW = $clog2(BITS_HI) + 1;

    logic            live_n;
    logic            bclk_prev, lr_prev;
    logic [CNTW-1:0] rise_cnt, exp_half;

    assign live_n   = init_rst_n && sys_rst_n;
    assign exp_half = use48 ? CNTW'(BITS_LO / 2) : CNTW'(BITS_HI / 2);

    always_ff @(posedge clk or negedge live_n) begin
        if (!live_n) begin
            bclk_prev <= 1'b0;
            lr_prev   <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            bclk_prev <= bclk_out;
            lr_prev   <= lrclk_out;
            if (lr_prev && !lrclk_out)      rise_cnt <= '0;
            else if (bclk_out && !bclk_prev) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R1 R2
    silent_in_reset_chk: assert property (@(negedge clk)
        (!init_rst_n || !sys_rst_n) |-> (!lrclk_out && !bclk_out));

    // R4
    slave_passthrough_chk: assert property (@(negedge clk) disable iff (!live_n)
        (st == ST_SLAVE) |-> (lrclk_out == lrclk_in && bclk_out == bclk_in));

    // R9
    lr_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!live_n)
        (st == ST_MASTER && lrclk_out != $past(lrclk_out)) |-> $fell(bclk_out));

    // R9 R8
    half_frame_bits_chk: assert property (@(posedge clk) disable iff (!live_n)
        (st == ST_MASTER && $rose(lrclk_out)) |-> (rise_cnt == exp_half));

    // R10
    err_frozen_chk: assert property (@(posedge clk) disable iff (!live_n)
        (st != ST_SILENT) |-> $stable(ratio_err));

endmodule

bind audio_clk_gen audio_clk_gen_chk #(
    .BITS_HI (BITS_HI),
    .BITS_LO (BITS_LO)
) u_chk (
    .clk        (clk),
    .init_rst_n (init_rst_n),
    .sys_rst_n  (sys_rst_n),
    .lrclk_in   (lrclk_in),
    .bclk_in    (bclk_in),
    .lrclk_out  (lrclk_out),
    .bclk_out   (bclk_out),
    .ratio_err  (ratio_err),
    .use48      (use48_q),
    .st         (state_q)
);

// File: tb/audio_clk_gen_bench.sv
`timescale 1ns/1ps
module audio_clk_gen_bench;

    logic       clk = 1'b0;
    logic       init_rst_n = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       master_mode = 1'b0;
    logic [1:0] clk_mode = 2'd0;
    logic       ratio48 = 1'b0;
    logic       lrclk_in = 1'b0;
    logic       bclk_in = 1'b0;
    logic       lrclk_out, bclk_out, ratio_err;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    audio_clk_gen u_audio_clk_gen (
        .clk         (clk),
        .init_rst_n  (init_rst_n),
        .sys_rst_n   (sys_rst_n),
        .master_mode (master_mode),
        .clk_mode    (clk_mode),
        .ratio48     (ratio48),
        .lrclk_in    (lrclk_in),
        .bclk_in     (bclk_in),
        .lrclk_out   (lrclk_out),
        .bclk_out    (bclk_out),
        .ratio_err   (ratio_err)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // {lrclk, bclk} after c counted master clocks in the frame
    function automatic logic [1:0] model(input int c, input int bits);
        int h;
        h = ((c % 256) * 2 * bits) / 256;
        return {(h >= bits), h[0]};
    endfunction

    task automatic do_reset(input logic m, input logic [1:0] ck, input logic r48);
        @(negedge clk);
        init_rst_n = 1'b0; sys_rst_n = 1'b0;
        #1;
        check("R1", {lrclk_out, bclk_out}, 2'b00);
        master_mode = m; clk_mode = ck; ratio48 = r48;
        lrclk_in = 1'b1; bclk_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {lrclk_out, bclk_out}, 2'b00);
        init_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2", {lrclk_out, bclk_out}, 2'b00);
        sys_rst_n = 1'b1;
        #1;
        check("R3", {lrclk_out, bclk_out}, 2'b00);
    endtask

    task automatic run_master(input logic [1:0] ck, input logic r48, input int bits,
                              input logic err_exp, input int ncyc, input int flip_at);
        do_reset(1'b1, ck, r48);
        check("R8", {1'b0, ratio_err}, {1'b0, err_exp});
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (bits == 64) check("R6", {lrclk_out, bclk_out}, model(k - 1, bits));
            else            check("R7", {lrclk_out, bclk_out}, model(k - 1, bits));
            if (k == flip_at) begin
                master_mode = 1'b0; ratio48 = ~ratio48; clk_mode = ~clk_mode;
                lrclk_in = 1'b0; bclk_in = 1'b0;
            end
            if (k > flip_at && flip_at > 0)
                check("R10", {lrclk_out, bclk_out, ratio_err} == {model(k - 1, bits), err_exp}
                      ? 2'b01 : 2'b00, 2'b01);
        end
        check("R5", {1'b0, ratio_err}, {1'b0, err_exp});
    endtask

    task automatic run_slave(input int flip_at);
        do_reset(1'b0, 2'd1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 96; i++) begin
            if (i == flip_at) begin
                master_mode = 1'b1; clk_mode = 2'd2; ratio48 = 1'b1;
            end
            lrclk_in = i[5];
            bclk_in  = i[0] ^ i[3];
            #1;
            check(i > flip_at ? "R10" : "R4", {lrclk_out, bclk_out}, {lrclk_in, bclk_in});
            @(negedge clk);
        end
    endtask

    initial begin
        #1;
        check("R1", {lrclk_out, bclk_out}, 2'b00);
        // 64fs in a permissive mode, cut mid-frame by the next reset (R11)
        run_master(2'd0, 1'b0, 64, 1'b0, 300, 0);
        run_master(2'd1, 1'b1, 48, 1'b0, 600, 0);
        // R11: restart after mid-frame interruption
        run_master(2'd1, 1'b1, 48, 1'b0, 140, 0);
        // R8: strict mode forces 64 and flags the request
        run_master(2'd2, 1'b1, 64, 1'b1, 540, 0);
        run_master(2'd2, 1'b0, 64, 1'b0, 260, 0);
        run_master(2'd3, 1'b1, 48, 1'b0, 520, 0);
        // R10: mode changes during a run are ignored
        run_master(2'd0, 1'b1, 48, 1'b0, 400, 100);
        run_master(2'd2, 1'b1, 64, 1'b1, 300, 50);
        run_slave(1000);
        run_slave(40);
        // R2: system reset during a master run silences at once
        run_master(2'd0, 1'b0, 64, 1'b0, 77, 0);
        sys_rst_n = 1'b0;
        #1;
        check("R2", {lrclk_out, bclk_out}, 2'b00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule